// File: doc/BRIEF.md
# 128-bit Lane Crossbar for 256-bit Vectors

This block rearranges whole 128-bit lanes of 256-bit vectors in a single registered stage. An opcode picks one of three operations. The two-source permute builds each result lane from a 4-bit control field of an 8-bit immediate. Each field can pick either lane of either source, or it can force the lane to zero. The insert operation replaces one lane of the first source with a 128-bit value. The extract operation copies one lane of the first source into the low 128 bits and clears the bits above it.

A vector-length input selects the operating width: 128 bits (one lane) or 256 bits (two lanes). The lane index for insert and extract is masked by the lane count, so in narrow mode it is always lane 0. Any result bits above the operating width are zero. The result and its valid strobe appear one clock after the input strobe. The result is held until the next accepted operation.

Top module: `lane_xbar`

## Requirements
- R1: During and right after an active-low reset, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` = 1. The result of that operation is on `out_data` in the same cycle.
- R3: Permute (opcode 0) builds result lane 0 (bits 127:0) from `imm[3:0]` and result lane 1 (bits 255:128) from `imm[7:4]`. In each field, bit 1 = 1 selects `src_b` and bit 1 = 0 selects `src_a`. Bit 0 selects the source lane (0 = bits 127:0, 1 = bits 255:128).
- R4: In a permute field, bit 3 = 1 makes that result lane all zeros, whatever the other bits of the field are.
- R5: Immediate bits 2 and 6 have no effect on the permute result.
- R6: Insert (opcode 1) writes `ins_val` into lane (`imm` AND (lanes − 1)). Every other lane is copied unchanged from `src_a`.
- R7: Extract (opcode 2) places lane (`imm` AND (lanes − 1)) of `src_a` in bits 127:0 of the result and makes bits 255:128 zero.
- R8: With `wide` = 0 (one lane), the lane count is 1. Insert and extract therefore use lane 0, and bits 255:128 of every result are zero. With `wide` = 1 the lane count is 2.
- R9: Opcode 3 is unsupported. It gives an all-zero result and still asserts `out_valid`.
- R10: In a cycle with `in_valid` = 0, the next `out_data` equals the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| opcode | input | 2 | 0 permute, 1 insert, 2 extract, 3 unsupported |
| wide | input | 1 | 1 = 256-bit operation, 0 = 128-bit operation |
| imm | input | 8 | Lane control immediate |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector (permute only) |
| ins_val | input | 128 | Value for insert |
| out_valid | output | 1 | Result strobe |
| out_data | output | 256 | Registered result |

## Verification
The only state is the output register and its strobe. A wrong selection, a missed zeroing or a bad index mask therefore shows at the ports in the first cycle after the strobe. Each such fault appears as one 128-bit half of `out_data` holding the wrong lane, or holding data where zeros are due. A register that reloads without a strobe shows in the next idle cycle as a change in `out_data` or a spurious `out_valid`. The random mix covers every control field value in both widths and so reaches each selection path.

// File: rtl/lane_xbar.sv
module lane_xbar #(
  parameter int LANE_W = 128,
  parameter int OPC_W  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [OPC_W-1:0]    opcode,
  input  logic                wide,
  input  logic [7:0]          imm,
  input  logic [2*LANE_W-1:0] src_a,
  input  logic [2*LANE_W-1:0] src_b,
  input  logic [LANE_W-1:0]   ins_val,
  output logic                out_valid,
  output logic [2*LANE_W-1:0] out_data
);
  localparam int VEC_W = 2 * LANE_W;
  localparam logic [OPC_W-1:0] OP_PERM = OPC_W'(0);
  localparam logic [OPC_W-1:0] OP_INS  = OPC_W'(1);
  localparam logic [OPC_W-1:0] OP_EXT  = OPC_W'(2);

  logic [LANE_W-1:0] a_ln [2];
  logic [LANE_W-1:0] b_ln [2];
  assign a_ln[0] = src_a[LANE_W-1:0];
  assign a_ln[1] = src_a[VEC_W-1:LANE_W];
  assign b_ln[0] = src_b[LANE_W-1:0];
  assign b_ln[1] = src_b[VEC_W-1:LANE_W];

  logic sel_idx;
  assign sel_idx = imm[0] & wide;

  logic unused_bits;
  assign unused_bits = ^{imm[6], imm[2]};

  for (genvar g = 0; g < 2; g++) begin : gl
    logic [3:0]        nib;
    logic [LANE_W-1:0] perm_v;
    logic [LANE_W-1:0] ins_v;
    logic [LANE_W-1:0] res;

    assign nib    = imm[4*g +: 4];
    assign perm_v = nib[3] ? '0 : (nib[1] ? b_ln[nib[0]] : a_ln[nib[0]]);
    assign ins_v  = (sel_idx == 1'(g)) ? ins_val : a_ln[g];

    always_comb begin
      case (opcode)
        OP_PERM: res = perm_v;
        OP_INS:  res = ins_v;
        OP_EXT:  res = (g == 0) ? a_ln[sel_idx] : '0;
        default: res = '0;
      endcase
      if (g == 1 && !wide) res = '0;
    end
  end

  logic [VEC_W-1:0] nxt;
  assign nxt = {gl[1].res, gl[0].res};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= nxt;
    end
  end
endmodule

module lane_xbar_chk #(
  parameter int LANE_W = 128,
  parameter int OPC_W  = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [OPC_W-1:0]    opcode,
  input logic                wide,
  input logic [7:0]          imm,
  input logic [2*LANE_W-1:0] src_a,
  input logic [2*LANE_W-1:0] src_b,
  input logic                out_valid,
  input logic [2*LANE_W-1:0] out_data
);
  localparam int VEC_W = 2 * LANE_W;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_data)); // R10
  AST_BAD_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && opcode == OPC_W'(3)) |=> out_data == '0); // R9
  AST_EXT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && opcode == OPC_W'(2)) |=> out_data[VEC_W-1:LANE_W] == '0); // R7
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !wide) |=> out_data[VEC_W-1:LANE_W] == '0); // R8
  AST_PERM_LO_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && opcode == OPC_W'(0) && imm[3]) |=> out_data[LANE_W-1:0] == '0); // R4
  AST_PERM_LO_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OPC_W'(0) && !imm[3] && imm[1] && imm[0]) |=> out_data[LANE_W-1:0] == $past(src_b[VEC_W-1:LANE_W])); // R3
endmodule

bind lane_xbar lane_xbar_chk #(.LANE_W(LANE_W), .OPC_W(OPC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .wide(wide),
  .imm(imm), .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/lane_xbar_test.sv
module lane_xbar_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   opcode = '0;
  logic         wide = 1'b0;
  logic [7:0]   imm = '0;
  logic [255:0] src_a = '0;
  logic [255:0] src_b = '0;
  logic [127:0] ins_val = '0;
  logic         out_valid;
  logic [255:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  lane_xbar uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .wide(wide),
    .imm(imm), .src_a(src_a), .src_b(src_b), .ins_val(ins_val),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [255:0] ref_out(input logic [1:0] op, input logic w,
      input logic [7:0] im, input logic [255:0] a, input logic [255:0] b, input logic [127:0] iv);
    logic [255:0] r;
    logic [127:0] lane;
    logic [3:0]   f;
    int           idx;
    r = '0;
    idx = w ? int'(im[0]) : 0;
    case (op)
      2'd0: for (int k = 0; k < 2; k++) begin
        f = im[4*k +: 4];
        if (f[3]) lane = '0;
        else if (f[1]) lane = b[128*f[0] +: 128];
        else lane = a[128*f[0] +: 128];
        r[128*k +: 128] = lane;
      end
      2'd1: begin
        r = a;
        r[128*idx +: 128] = iv;
      end
      2'd2: r[127:0] = a[128*idx +: 128];
      default: r = '0;
    endcase
    if (!w) r[255:128] = '0;
    return r;
  endfunction

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [1:0] op, input logic w, input logic [7:0] im,
      input logic [255:0] a, input logic [255:0] b, input logic [127:0] iv);
    logic [255:0] exp;
    exp = ref_out(op, w, im, a, b, iv);
    @(negedge clk);
    in_valid = 1'b1; opcode = op; wide = w; imm = im; src_a = a; src_b = b; ins_val = iv;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R2 valid"}, {255'd0, out_valid}, 256'd1);
    check(tag, out_data, exp);
  endtask

  function automatic logic [255:0] rnd256(inout int unsigned s);
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[32*k +: 32] = $urandom(s);
    return v;
  endfunction

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [255:0] A, B, held;
    logic [127:0] V;
    int unsigned seed;
    seed = 32'h5EED_1234;
    A = {64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, 64'h3333_3333_3333_3333, 64'h4444_4444_4444_4444};
    B = {64'hAAAA_AAAA_AAAA_AAAA, 64'hBBBB_BBBB_BBBB_BBBB, 64'hCCCC_CCCC_CCCC_CCCC, 64'hDDDD_DDDD_DDDD_DDDD};
    V = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

    repeat (3) @(negedge clk);
    check("R1 data", out_data, '0);
    check("R1 valid", {255'd0, out_valid}, '0);
    rst_n = 1'b1;

    run("R3 b.hi/a.hi", 2'd0, 1'b1, 8'h31, A, B, V);
    check("R3 lane pick", out_data, {B[255:128], A[255:128]});
    run("R3 a.lo/b.lo", 2'd0, 1'b1, 8'h20, A, B, V);
    run("R4 both zero", 2'd0, 1'b1, 8'h88, A, B, V);
    run("R4 zero overrides", 2'd0, 1'b1, 8'h3B, A, B, V);
    check("R4 lo zero", {128'd0, out_data[127:0]}, '0);
    run("R5 ignored bits", 2'd0, 1'b1, 8'h45, A, B, V);
    check("R5 same as 0x01", out_data, ref_out(2'd0, 1'b1, 8'h01, A, B, V));
    run("R6 insert hi", 2'd1, 1'b1, 8'h03, A, B, V);
    run("R6 insert lo", 2'd1, 1'b1, 8'hFE, A, B, V);
    run("R7 extract hi", 2'd2, 1'b1, 8'h01, A, B, V);
    run("R7 extract masked", 2'd2, 1'b1, 8'h02, A, B, V);
    run("R8 narrow insert", 2'd1, 1'b0, 8'h01, A, B, V);
    run("R8 narrow extract", 2'd2, 1'b0, 8'h01, A, B, V);
    run("R8 narrow permute", 2'd0, 1'b0, 8'h13, A, B, V);
    run("R9 bad opcode", 2'd3, 1'b1, 8'h31, A, B, V);
    run("R9 setup", 2'd0, 1'b1, 8'h32, A, B, V);
    held = out_data;
    @(negedge clk);
    opcode = 2'd1; imm = 8'h00; src_a = B; ins_val = ~V;
    @(negedge clk);
    check("R10 hold", out_data, held);
    check("R2 no valid", {255'd0, out_valid}, '0);

    for (int n = 0; n < 400; n++) begin
      logic [1:0]   op;
      logic         w;
      logic [7:0]   im;
      logic [255:0] ra, rb;
      logic [127:0] rv;
      string        t;
      op = 2'($urandom(seed));
      w  = ($urandom(seed) % 4) != 0;
      im = 8'($urandom(seed));
      ra = rnd256(seed);
      rb = rnd256(seed);
      rv = rnd256(seed)[127:0];
      case (op)
        2'd0: t = "R3 rand permute";
        2'd1: t = "R6 rand insert";
        2'd2: t = "R7 rand extract";
        default: t = "R9 rand bad";
      endcase
      if (!w) t = {t, " R8 narrow"};
      run(t, op, w, im, ra, rb, rv);
      if ((n % 7) == 0) begin
        held = out_data;
        @(negedge clk);
        check("R10 rand hold", out_data, held);
      end
    end

    done = 1'b1;
    summary();
  end
endmodule